// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave. It gives an external controller access to a small bank of configuration bytes inside a clock generator. It samples SCL and SDA with the system clock, cleans both lines and finds START and STOP conditions. It answers one fixed 7-bit address and pulls SDA low through an open-drain enable when it acknowledges or sends a zero.

The command byte that follows the address picks the access type. With the top bit set, the low seven bits name one byte for a single-byte read or write. With the top bit clear, the access is a block transfer that starts at byte 0. A block write carries a byte count ahead of its data. A block read returns a byte count ahead of its data. Reads turn the bus around with a repeated START and a read address. The bank holds reset defaults, per-bit write masks, a read-only identification byte and a read-only byte of strap bits captured just after reset. The configuration bytes are also presented in parallel to the rest of the clock generator.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset every byte holds its default. Offset 0 holds 12h, offset 1 holds 00h in bits 7:4 and, in bits 3:0, the strap_i value captured on the first clock after reset. Offset 2 holds 0Ah, offset 3 FFh, offset 4 the identification byte (81h), offset 5 B0h, offset 6 FFh and offset 7 00h. Later changes of strap_i have no effect.
- R2: The slave acknowledges only an address byte whose upper seven bits equal 1101001 (D2h write, D3h read). It leaves every other address and the rest of that transaction unacknowledged and has no effect on the registers.
- R3: A byte write is address+W, then a command with bit 7 = 1 and the offset in bits 6:0, then a data byte. Every one of these bytes is acknowledged, and the data is stored under the write mask of that offset.
- R4: A byte read is address+W, then a command with bit 7 = 1, a repeated START and address+R. The slave then returns the byte at that offset, most significant bit first.
- R5: A block write is address+W, then command 00h, a count N and data bytes. Every byte is acknowledged. Data bytes go to offsets 0,1,2,… in order, and bytes beyond the first N are not stored.
- R6: A block read is address+W, then command 00h, a repeated START and address+R. The slave returns the count NUM_REGS (08h) and then offsets 0,1,2,… in order until the master answers with NACK, which may come after any byte.
- R7: Write masks per offset are 3Fh, 00h, 3Fh, FFh, 00h, BFh, FFh and 9Fh for offsets 0 to 7. Bits outside a mask never change. Offsets at or above NUM_REGS accept writes with an acknowledge, store nothing and read as 00h.
- R8: A STOP inside a byte aborts the transaction: the partial byte is not stored, and the next transaction works normally.
- R9: A pulse on SCL shorter than FILT_LEN system clocks is ignored. A data byte sent with such a glitch inside one of its high phases is stored intact.
- R10: The SDA drive enable is off after reset and after every STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_i | input | 4 | Frequency strap pins, captured once after reset |
| cfg_o | output | NUM_REGS*8 | All configuration bytes, offset k in bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: own address 69h, eight implemented bytes and a three-clock glitch filter. With eight bytes, a full block read returns every default and every masked write, and offsets 8 and 9 exercise the unimplemented range. With a three-clock filter and eight system clocks per quarter bit, a one-clock SCL glitch falls well under the threshold while real edges pass. Random single-byte writes and reads at offsets 0 to 9 are mixed with directed block transfers, a foreign address, an early block-read NACK and a STOP in mid-byte, all against a bench-side model of defaults and masks.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;

  localparam int STRAP_W   = 4;
  localparam int STRAP_IDX = 1;
  localparam int ID_IDX    = 4;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK, PH_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    RL_ADDR, RL_CMD, RL_CNT, RL_DAT
  } role_t;

  // power-up value of each writable byte
  function automatic logic [7:0] reg_default(int idx);
    case (idx)
      0: return 8'h12;
      2: return 8'h0A;
      3: return 8'hFF;
      5: return 8'hB0;
      6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // bits a write may change; zero for read-only bytes
  function automatic logic [7:0] reg_wmask(int idx);
    case (idx)
      0: return 8'h3F;
      1: return 8'h00;
      2: return 8'h3F;
      3: return 8'hFF;
      4: return 8'h00;
      5: return 8'hBF;
      6: return 8'hFF;
      7: return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] masked_merge(logic [7:0] old_v, logic [7:0] new_v,
                                              logic [7:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  function automatic logic addr_hit(logic [7:0] b, logic [6:0] own);
    return b[7:1] == own;
  endfunction

endpackage

// File: rtl/cfg_line_filter.sv
module cfg_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic out_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      out_o  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == out_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        out_o <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R9: the filtered line only ever moves to the value just sampled
  p_filter_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_o != $past(out_o)) |-> (out_o == $past(sync_q[1])));

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank import cfg_smbus_pkg::*; #(
  parameter int         NUM_REGS = 8,
  parameter logic [7:0] ID_BYTE  = 8'h81
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [6:0]              wr_addr_i,
  input  logic [7:0]              wr_data_i,
  input  logic [6:0]              rd_addr_i,
  output logic [7:0]              rd_data_o,
  input  logic [STRAP_W-1:0]      strap_i,
  output logic [NUM_REGS*8-1:0]   flat_o
);

  logic               taken_q;
  logic [STRAP_W-1:0] strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      strap_q <= '0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      strap_q <= strap_i;
    end
  end

  // R1: the strap copy is frozen once taken
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_q && $past(taken_q)) |-> $stable(strap_q));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    if (i == STRAP_IDX) begin : g_strap
      assign flat_o[i*8 +: 8] = {{(8-STRAP_W){1'b0}}, strap_q};
    end else if (i == ID_IDX) begin : g_id
      assign flat_o[i*8 +: 8] = ID_BYTE;
    end else begin : g_rw
      localparam logic [7:0] MASK = reg_wmask(i);
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          byte_q <= reg_default(i);
        else if (wr_en_i && wr_addr_i == 7'(i))
          byte_q <= masked_merge(byte_q, wr_data_i, MASK);
      end
      assign flat_o[i*8 +: 8] = byte_q;

      // R7: bits outside the write mask never move
      p_masked_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(byte_q & ~MASK));
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == 7'(i)) rd_data_o = flat_o[i*8 +: 8];
  end

endmodule

// File: rtl/cfg_smbus_engine.sv
module cfg_smbus_engine import cfg_smbus_pkg::*; #(
  parameter logic [6:0] OWN_ADDR = 7'h69,
  parameter int         NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] rd_data_i,
  output logic [6:0] rd_addr_o,
  output logic       wr_en_o,
  output logic [6:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  localparam logic [7:0] BLK_COUNT = 8'(NUM_REGS);

  logic       scl_d, sda_d;
  phase_t     phase;
  role_t      role;
  logic [3:0] rxcnt;
  logic [2:0] txcnt;
  logic [7:0] sr, txsr, wr_left;
  logic [6:0] ptr;
  logic       rw, blk, cnt_pending, m_nack;

  // named bus events
  logic start_ev, stop_ev, scl_rise, scl_fall, byte_done, own_hit;
  assign start_ev  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev   = scl_f & scl_d & ~sda_d & sda_f;
  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign byte_done = (phase == PH_RX) && scl_fall && (rxcnt == 4'd8);
  assign own_hit   = addr_hit(sr, OWN_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;     role <= RL_ADDR;
      rxcnt <= '0;          txcnt <= '0;
      sr <= '0;             txsr <= '0;      wr_left <= '0;
      ptr <= '0;            rw <= 1'b0;      blk <= 1'b1;
      cnt_pending <= 1'b0;  m_nack <= 1'b0;
    end else if (start_ev) begin
      phase <= PH_RX;  role <= RL_ADDR;  rxcnt <= '0;
      rw <= 1'b0;      cnt_pending <= 1'b0;
    end else if (stop_ev) begin
      phase <= PH_IDLE;  rw <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise && rxcnt != 4'd8) begin
            sr    <= {sr[6:0], sda_f};
            rxcnt <= rxcnt + 1'b1;
          end else if (byte_done) begin
            rxcnt <= '0;
            case (role)
              RL_ADDR: begin
                if (own_hit) begin
                  phase       <= PH_RXACK;
                  rw          <= sr[0];
                  cnt_pending <= sr[0] & blk;
                  role        <= RL_CMD;
                end else begin
                  phase <= PH_WAIT;
                end
              end
              RL_CMD: begin
                blk   <= ~sr[7];
                ptr   <= sr[7] ? sr[6:0] : 7'd0;
                role  <= sr[7] ? RL_DAT : RL_CNT;
                phase <= PH_RXACK;
              end
              RL_CNT: begin
                wr_left <= sr;
                role    <= RL_DAT;
                phase   <= PH_RXACK;
              end
              default: begin
                ptr <= ptr + 1'b1;
                if (blk && wr_left != 8'd0) wr_left <= wr_left - 1'b1;
                phase <= PH_RXACK;
              end
            endcase
          end
        end
        PH_RXACK: begin
          if (scl_fall) begin
            if (rw) begin
              phase <= PH_TX;
              txcnt <= '0;
              if (cnt_pending) begin
                txsr <= BLK_COUNT;  cnt_pending <= 1'b0;
              end else begin
                txsr <= rd_data_i;  ptr <= ptr + 1'b1;
              end
            end else begin
              phase <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (txcnt == 3'd7) begin
              phase <= PH_TXACK;
            end else begin
              txsr  <= {txsr[6:0], 1'b0};
              txcnt <= txcnt + 1'b1;
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise) m_nack <= sda_f;
          if (scl_fall) begin
            if (!m_nack) begin
              phase <= PH_TX;
              txcnt <= '0;
              if (cnt_pending) begin
                txsr <= BLK_COUNT;  cnt_pending <= 1'b0;
              end else begin
                txsr <= rd_data_i;  ptr <= ptr + 1'b1;
              end
            end else begin
              phase <= PH_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr_o = ptr;
  assign wr_addr_o = ptr;
  assign wr_data_o = sr;
  assign wr_en_o   = byte_done && (role == RL_DAT) && (!blk || wr_left != 8'd0);
  assign sda_oe_o  = (phase == PH_RXACK) || (phase == PH_TX && !txsr[7]);

  // R2: acknowledge own address, stay silent otherwise
  p_ack_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && role == RL_ADDR && own_hit) |=> sda_oe_o);
  p_silent_foreign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && role == RL_ADDR && !own_hit) |=> !sda_oe_o);
  // R10: STOP releases the line
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe_o);
  // R8: any START rearms address reception from bit zero
  p_start_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (phase == PH_RX && rxcnt == 4'd0));

endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave import cfg_smbus_pkg::*; #(
  parameter logic [6:0] OWN_ADDR = 7'h69,
  parameter int         NUM_REGS = 8,
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] ID_BYTE  = 8'h81
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic       scl_f, sda_f;
  logic       wr_en;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  cfg_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .out_o(scl_f));

  cfg_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .out_o(sda_f));

  cfg_smbus_engine #(.OWN_ADDR(OWN_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_oe_o(sda_oe_o));

  cfg_regbank #(.NUM_REGS(NUM_REGS), .ID_BYTE(ID_BYTE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .strap_i(strap_i), .flat_o(cfg_o));

endmodule

// File: tb/sim_cfg_smbus_slave.sv
module sim_cfg_smbus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NREG       = 8;
  localparam logic [6:0] OWN = 7'h69;

  logic clk = 1'b0;
  logic rst_n, scl, sda_m, sda_oe;
  logic [3:0] strap;
  logic [NREG*8-1:0] cfg;
  logic sda_bus;
  int total = 0, bad = 0;
  logic done = 1'b0;
  logic [7:0] model [NREG];

  assign sda_bus = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_smbus_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .cfg_o(cfg));

  function automatic logic [7:0] b_def(int k);
    case (k)
      0: return 8'h12;  1: return 8'h0A;  2: return 8'h0A;  3: return 8'hFF;
      4: return 8'h81;  5: return 8'hB0;  6: return 8'hFF;  default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] b_mask(int k);
    case (k)
      0: return 8'h3F;  2: return 8'h3F;  3: return 8'hFF;  5: return 8'hBF;
      6: return 8'hFF;  7: return 8'h9F;  default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] expect_rd(int k);
    return (k < NREG) ? model[k] : 8'h00;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask
  task automatic send_bit(logic b, logic glitch);
    sda_m = b; wq(Q); scl = 1'b1; wq(Q);
    if (glitch) begin scl = 1'b0; wq(1); scl = 1'b1; wq(Q-1); end
    else wq(Q);
    scl = 1'b0; wq(Q);
  endtask
  task automatic send_byte(logic [7:0] v, logic glitch, output logic acked);
    for (int k = 7; k >= 0; k--) send_bit(v[k], glitch && k == 3);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); acked = !sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic recv_byte(logic ack_it, output logic [7:0] v);
    sda_m = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      wq(Q); scl = 1'b1; wq(Q); v[k] = sda_bus; wq(Q); scl = 1'b0;
    end
    wq(1);
    send_bit(!ack_it, 1'b0);
  endtask

  task automatic byte_write(logic [6:0] adr, logic [6:0] off, logic [7:0] d,
                            logic glitch, string tag);
    logic a0, a1, a2;
    bus_start;
    send_byte({adr, 1'b0}, 1'b0, a0);
    send_byte({1'b1, off}, 1'b0, a1);
    send_byte(d, glitch, a2);
    bus_stop;
    if (adr == OWN) begin
      check({tag, " R3 acks"}, {a0, a1, a2}, 3'b111);
      if (off < NREG) model[off] = (model[off] & ~b_mask(off)) | (d & b_mask(off));
    end else begin
      check({tag, " R2 foreign not acked"}, a0, 0);
    end
    check({tag, " R10 released after stop"}, sda_oe, 0);
  endtask

  task automatic byte_read(logic [6:0] off, string tag);
    logic a0, a1, a2;
    logic [7:0] v;
    bus_start;
    send_byte({OWN, 1'b0}, 1'b0, a0);
    send_byte({1'b1, off}, 1'b0, a1);
    bus_start;
    send_byte({OWN, 1'b1}, 1'b0, a2);
    recv_byte(1'b0, v);
    bus_stop;
    check({tag, " R4 acks"}, {a0, a1, a2}, 3'b111);
    check({tag, " R4 data"}, v, expect_rd(off));
  endtask

  task automatic block_read(int n, string tag);
    logic a0, a1, a2;
    logic [7:0] v;
    bus_start;
    send_byte({OWN, 1'b0}, 1'b0, a0);
    send_byte(8'h00, 1'b0, a1);
    bus_start;
    send_byte({OWN, 1'b1}, 1'b0, a2);
    check({tag, " R6 acks"}, {a0, a1, a2}, 3'b111);
    recv_byte(n != 0, v);
    check({tag, " R6 count"}, v, NREG);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, v);
      check($sformatf("%s R6 byte %0d", tag, k), v, expect_rd(k));
    end
    bus_stop;
  endtask

  task automatic block_write(int n, int extra, string tag);
    logic a;
    logic [7:0] d;
    int acks = 0;
    bus_start;
    send_byte({OWN, 1'b0}, 1'b0, a); acks += a;
    send_byte(8'h00, 1'b0, a);       acks += a;
    send_byte(8'(n), 1'b0, a);       acks += a;
    for (int k = 0; k < n + extra; k++) begin
      d = 8'($urandom);
      send_byte(d, 1'b0, a); acks += a;
      if (k < n && k < NREG) model[k] = (model[k] & ~b_mask(k)) | (d & b_mask(k));
    end
    bus_stop;
    check({tag, " R5 every byte acked"}, acks, 3 + n + extra);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; strap = 4'hA;
    for (int k = 0; k < NREG; k++) model[k] = b_def(k);
    wq(5); rst_n = 1'b1; wq(5);

    // R1: defaults at reset, seen on the parallel outputs
    for (int k = 0; k < NREG; k++) check($sformatf("R1 reset byte %0d", k), cfg[k*8 +: 8], model[k]);
    check("R10 no drive after reset", sda_oe, 0);
    strap = 4'h5;
    wq(4);
    check("R1 strap frozen", cfg[15:8], 8'h0A);

    block_read(NREG, "reset");
    byte_write(OWN, 7'd0, 8'hFF, 1'b0, "R7 mask off0");
    byte_read(7'd0, "R7 masked readback");
    byte_write(OWN, 7'd4, 8'h00, 1'b0, "R7 id byte");
    byte_read(7'd4, "R7 id unchanged");
    byte_write(OWN, 7'd1, 8'hFF, 1'b0, "R7 strap byte");
    byte_read(7'd1, "R7 strap unchanged");
    byte_write(OWN, 7'd9, 8'h5A, 1'b0, "R7 past end");
    byte_read(7'd9, "R7 past end reads zero");

    byte_write(7'h68, 7'd3, 8'h00, 1'b0, "R2 near address");
    byte_write(7'h29, 7'd6, 8'h00, 1'b0, "R2 far address");
    byte_read(7'd3, "R2 off3 intact");
    byte_read(7'd6, "R2 off6 intact");

    block_write(3, 2, "R5 short count");
    block_read(NREG, "R5 after short block");
    block_write(NREG, 0, "R5 full block");
    block_read(NREG, "R6 full");
    block_read(2, "R6 early nack");

    // R8: STOP after four data bits aborts the write
    bus_start;
    send_byte({OWN, 1'b0}, 1'b0, a);
    send_byte({1'b1, 7'd3}, 1'b0, a);
    for (int k = 0; k < 4; k++) send_bit(1'b0, 1'b0);
    bus_stop;
    check("R10 released after abort", sda_oe, 0);
    byte_read(7'd3, "R8 partial byte dropped");
    check("R8 parallel view intact", cfg[31:24], model[3]);

    // R9: one-clock SCL glitch inside a data bit
    byte_write(OWN, 7'd6, 8'hC3, 1'b1, "R9 glitch write");
    byte_read(7'd6, "R9 glitch data intact");

    for (int n = 0; n < 20; n++) begin
      logic [6:0] off;
      off = 7'($urandom_range(0, 9));
      byte_write(OWN, off, 8'($urandom), 1'b0, "R3 random");
      off = 7'($urandom_range(0, 9));
      byte_read(off, "R4 random");
    end
    block_read(NREG, "R6 final");
    for (int k = 0; k < NREG; k++) check($sformatf("R3 final byte %0d", k), cfg[k*8 +: 8], model[k]);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule